// File: doc/BRIEF.md
# Tone Steering Guard-Time Validator

This block sits behind a dual-tone decoder. The decoder supplies an early detection flag and a 4-bit key code. The block replaces an analog steering time constant with two digital guard counters that count a slow timebase tick, normally one tick per millisecond. A key is accepted only after the early flag has held high for a programmable number of ticks. The code is then captured into an output latch. A fixed number of clock cycles later, a tone-valid flag rises, so the data is stable before the flag announces it.

Once a key is accepted, gaps in the early flag are bridged unless they last for a second, separately programmable number of ticks. When a gap is long enough, the tone-valid flag drops and the block is ready for the next key. The total acceptance time is the decoder's own detect time plus the first count. The total pause time is the decoder's release time plus the second count. Typical settings are about 40 ticks for each.

The latched code appears on the data outputs only while the output enable is high. The high-impedance condition is modelled as a separate drive-enable output, with the data forced to zero while it is off.

Top module: `steer_guard`

## Requirements
- R1: A key is accepted only when `early_i` stays high for `acc_ticks_i` ticks in a row. A tick is a cycle with `tick_i` high, and counting starts the cycle after `early_i` is first seen high. A shorter burst changes neither `tone_valid_o` nor the latch.
- R2: On the clock edge that accepts a key, `code_i` is captured into the latch. `tone_valid_o` rises exactly `SETTLE_CYC` cycles after that edge (default 4).
- R3: While `tone_valid_o` is high, a drop of `early_i` that lasts fewer than `gap_ticks_i` ticks keeps `tone_valid_o` high. The code that is present when the flag returns is not latched.
- R4: `tone_valid_o` falls on the edge of the tick that completes `gap_ticks_i` ticks of `early_i` low. After that, a new key can be accepted.
- R5: The latch holds the code of the last accepted key until another key is accepted.
- R6: `code_oe_o` equals `oe_i`. `code_o` carries the latched code while `oe_i` is 1 and is all zeros while `oe_i` is 0.
- R7: After reset, `tone_valid_o` is 0 and the latch holds 0.
- R8: Both guard counters restart from zero whenever `early_i` changes level before the count completes.
- R9: If `early_i` returns high in the same cycle as the tick that would complete the gap count, the gap is bridged and `tone_valid_o` stays high.
- R10: A guard setting of 0 behaves like a setting of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one cycle wide |
| early_i | input | 1 | Early detection flag from the decoder |
| code_i | input | CODE_W | Key code from the decoder |
| acc_ticks_i | input | TIME_W | Acceptance guard, in ticks |
| gap_ticks_i | input | TIME_W | Pause guard, in ticks |
| oe_i | input | 1 | Output enable |
| code_o | output | CODE_W | Latched code, zero when not driven |
| code_oe_o | output | 1 | Drive enable for code_o |
| tone_valid_o | output | 1 | Delayed tone-valid flag |

## Verification
The pause counter completing and the early flag returning can fall on the same edge. The bench provokes this by raising `early_i` and `tick_i` together after `gap_ticks_i - 1` gap ticks. It judges the result by `tone_valid_o` staying high, and by a following gap needing the full count again. A second collision is a new code arriving while the flag is high. The bench sweeps the gap length across the guard boundary and checks `code_o` against the last accepted key after each gap.

// File: rtl/steer_guard_pkg.sv
`timescale 1ns/1ps
package steer_guard_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_SETTLE,
    ST_HOLD,
    ST_GAP
  } steer_st_e;
endpackage

// File: rtl/guard_cnt.sv
`timescale 1ns/1ps
module guard_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  localparam int EW = W + 1;
  logic [W-1:0]  cnt_q;
  logic [EW-1:0] nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // limit 0 compares true on first increment, same as limit 1
  assign nxt   = {1'b0, cnt_q} + EW'(1);
  assign hit_o = inc_i && (nxt >= {1'b0, limit_i});
endmodule

// File: rtl/steer_fsm.sv
`timescale 1ns/1ps
module steer_fsm
  import steer_guard_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      early_i,
  input  logic      acc_hit_i,
  input  logic      gap_hit_i,
  input  logic      settle_hit_i,
  output steer_st_e st_o,
  output logic      load_o,
  output logic      valid_o
);
  steer_st_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (early_i) st_d = ST_ACQ;
      ST_ACQ: begin
        if (!early_i) st_d = ST_IDLE;
        else if (acc_hit_i) begin
          st_d   = ST_SETTLE;
          load_o = 1'b1;
        end
      end
      ST_SETTLE: if (settle_hit_i) st_d = ST_HOLD;
      ST_HOLD:   if (!early_i) st_d = ST_GAP;
      ST_GAP: begin
        if (early_i) st_d = ST_HOLD;     // return wins over final tick
        else if (gap_hit_i) st_d = ST_IDLE;
      end
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o    = st_q;
  assign valid_o = (st_q == ST_HOLD) || (st_q == ST_GAP);
endmodule

// File: rtl/code_latch.sv
`timescale 1ns/1ps
module code_latch #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  input  logic         oe_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] bus_o,
  output logic         bus_oe_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= d_i;
  end

  assign q_o      = q_q;
  assign bus_oe_o = oe_i;
  assign bus_o    = oe_i ? q_q : '0;
endmodule

// File: rtl/steer_guard.sv
`timescale 1ns/1ps
module steer_guard
  import steer_guard_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int TIME_W     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              early_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [TIME_W-1:0] acc_ticks_i,
  input  logic [TIME_W-1:0] gap_ticks_i,
  input  logic              oe_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_oe_o,
  output logic              tone_valid_o
);
  localparam int SET_N = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;
  localparam int SET_W = $clog2(SET_N + 1);

  steer_st_e         st;
  logic              acc_hit, gap_hit, settle_hit, load;
  logic              acc_run, gap_run, set_run;
  logic [CODE_W-1:0] lat_q;

  assign acc_run = (st == ST_ACQ) && early_i;
  assign gap_run = (st == ST_GAP) && !early_i;
  assign set_run = (st == ST_SETTLE);

  guard_cnt #(.W(TIME_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!acc_run),
    .inc_i(acc_run && tick_i), .limit_i(acc_ticks_i), .hit_o(acc_hit)
  );

  guard_cnt #(.W(TIME_W)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!gap_run),
    .inc_i(gap_run && tick_i), .limit_i(gap_ticks_i), .hit_o(gap_hit)
  );

  guard_cnt #(.W(SET_W)) u_set (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!set_run),
    .inc_i(set_run), .limit_i(SET_W'(SET_N)), .hit_o(settle_hit)
  );

  steer_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .early_i(early_i),
    .acc_hit_i(acc_hit), .gap_hit_i(gap_hit), .settle_hit_i(settle_hit),
    .st_o(st), .load_o(load), .valid_o(tone_valid_o)
  );

  code_latch #(.W(CODE_W)) u_lat (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .d_i(code_i),
    .oe_i(oe_i), .q_o(lat_q), .bus_o(code_o), .bus_oe_o(code_oe_o)
  );
endmodule

// File: rtl/steer_guard_chk.sv
`timescale 1ns/1ps
module steer_guard_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              early_i,
  input logic [CODE_W-1:0] lat_q,
  input logic [CODE_W-1:0] code_o,
  input logic              code_oe_o,
  input logic              tone_valid_o
);
  // R1: latch moves only on a tick edge with early high
  p_load_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lat_q) |-> ($past(tick_i) && $past(early_i)));

  // R2: flag rises only with data already settled
  p_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tone_valid_o) |-> $stable(lat_q));

  // R3: no latch update while flag is up
  p_no_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lat_q) |-> (!$past(tone_valid_o) && !tone_valid_o));

  // R4: flag falls only on a tick with early low
  p_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tone_valid_o) |-> ($past(tick_i) && !$past(early_i)));

  // R6: undriven bus reads zero
  p_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_oe_o |-> (code_o == '0));
endmodule

bind steer_guard steer_guard_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .early_i(early_i),
  .lat_q(lat_q), .code_o(code_o), .code_oe_o(code_oe_o),
  .tone_valid_o(tone_valid_o)
);

// File: tb/sim_steer_guard.sv
`timescale 1ns/1ps
module sim_steer_guard;
  localparam int CW = 4;
  localparam int TW = 8;
  localparam int S  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, early = 1'b0, oe = 1'b1;
  logic [CW-1:0] code = '0;
  logic [TW-1:0] acc = 8'd2, gap = 8'd3;
  logic [CW-1:0] code_o;
  logic          code_oe, valid;
  int            n_run = 0, n_fail = 0;
  int            exp_code = 0;

  always #10 clk = ~clk;

  steer_guard #(.CODE_W(CW), .TIME_W(TW), .SETTLE_CYC(S)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .early_i(early),
    .code_i(code), .acc_ticks_i(acc), .gap_ticks_i(gap), .oe_i(oe),
    .code_o(code_o), .code_oe_o(code_oe), .tone_valid_o(valid)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) tick1();
  endtask

  task automatic accept(input logic [CW-1:0] c);
    code = c; early = 1'b1; cyc(2);
    ticks((acc == 0) ? 1 : int'(acc));
    cyc(S + 2);
    exp_code = int'(c);
  endtask

  task automatic release_all();
    early = 1'b0; cyc(2);
    ticks((gap == 0) ? 1 : int'(gap));
    cyc(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    cyc(3);
    // R7: reset state
    chk(valid == 1'b0, "R7 valid", int'(valid), 0);
    chk(code_o == '0, "R7 latch", int'(code_o), 0);
    rst_n = 1'b1;
    cyc(2);

    // R1 R5 R10: burst length swept across acceptance guard
    gap = 8'd3;
    for (int p = 0; p <= 4; p++) begin
      acc = TW'(p);
      for (int l = 0; l <= ((p == 0) ? 1 : p) + 1; l++) begin
        automatic int  c   = (p * 5 + l + 1) & 15;
        automatic bit  reg_ok = (l >= ((p == 0) ? 1 : p));
        code = CW'(c); early = 1'b1; cyc(2);
        ticks(l);
        cyc(S + 2);
        if (reg_ok) exp_code = c;
        chk(valid == reg_ok, (p == 0) ? "R10 flag" : "R1 flag", int'(valid), int'(reg_ok));
        chk(int'(code_o) == exp_code, "R5 latch", int'(code_o), exp_code);
        release_all();
        chk(valid == 1'b0, "R4 release", int'(valid), 0);
      end
    end

    // R2: settle delay counted per cycle
    acc = 8'd1;
    code = 4'hA; early = 1'b1; cyc(2);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk(code_o == 4'hA, "R2 data first", int'(code_o), 10);
    chk(valid == 1'b0, "R2 flag low at load", int'(valid), 0);
    for (int k = 1; k < S; k++) begin
      @(negedge clk);
      chk(valid == 1'b0, "R2 flag low in settle", int'(valid), 0);
    end
    @(negedge clk);
    chk(valid == 1'b1, "R2 flag up after settle", int'(valid), 1);
    exp_code = 10;
    release_all();

    // R3 R4: dropout length swept across gap guard, new code offered
    acc = 8'd2;
    for (int a = 1; a <= 4; a++) begin
      gap = TW'(a);
      for (int d = 0; d <= a + 1; d++) begin
        automatic int x = (a * 3 + d) & 15;
        automatic int y = (x + 7) & 15;
        accept(CW'(x));
        early = 1'b0; cyc(2);
        ticks(d);
        chk(valid == (d < a), "R3 bridge flag", int'(valid), int'(d < a));
        code = CW'(y); early = 1'b1; cyc(2);
        ticks(2);
        cyc(S + 2);
        if (d >= a) exp_code = y;
        chk(valid == 1'b1, "R4 flag after return", int'(valid), 1);
        chk(int'(code_o) == exp_code, "R3 latch held or R4 reload", int'(code_o), exp_code);
        release_all();
      end
    end

    // R9 R8: early returns on the completing tick, then counter restarts
    gap = 8'd3;
    accept(4'h5);
    early = 1'b0; cyc(2);
    ticks(2);
    early = 1'b1; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    cyc(1);
    chk(valid == 1'b1, "R9 same-cycle bridge", int'(valid), 1);
    early = 1'b0; cyc(2);
    ticks(2);
    chk(valid == 1'b1, "R8 gap count restarted", int'(valid), 1);
    tick1();
    chk(valid == 1'b0, "R8 full gap after restart", int'(valid), 0);

    // R8: acceptance count restarts after a short burst
    acc = 8'd3;
    code = 4'h9; early = 1'b1; cyc(2); ticks(2);
    early = 1'b0; cyc(2);
    early = 1'b1; cyc(2); ticks(2); cyc(S + 2);
    chk(valid == 1'b0, "R8 acc count restarted", int'(valid), 0);
    chk(int'(code_o) == exp_code, "R8 latch held", int'(code_o), exp_code);
    tick1(); cyc(S + 2);
    exp_code = 9;
    chk(valid == 1'b1, "R8 accept after full count", int'(valid), 1);

    // R6: output enable gating
    oe = 1'b0; cyc(1);
    chk(code_oe == 1'b0, "R6 oe off", int'(code_oe), 0);
    chk(code_o == '0, "R6 bus zero", int'(code_o), 0);
    oe = 1'b1; cyc(1);
    chk(code_oe == 1'b1, "R6 oe on", int'(code_oe), 1);
    chk(int'(code_o) == exp_code, "R6 bus data", int'(code_o), exp_code);

    summary();
    $finish;
  end
endmodule